// File: doc/BRIEF.md
# CORDIC sine DDS generator

This block is a direct digital synthesizer that produces a signed sine sample. A phase register adds a tuning word to itself on every enabled cycle. Its value drives a pipelined CORDIC rotator, which runs in rotation mode and yields the sine of that phase. The rotator result is then fitted to an output word whose width is chosen apart from the rotator's own width. If the output is narrower, the result is rounded half-up. If it is wider, the result is shifted left.

All datapath stages advance only while the downstream enable `en` is high. When `en` is low the block freezes: the phase, the pipeline, the output and the valid flag keep their values. Reset is synchronous and active low. It touches only the valid chain and loads the starting phase. The pipeline registers have no reset.

The phase is an unsigned PW-bit fraction of a full turn, so code p stands for 2π·p/2^PW. The two top phase bits pick a quadrant, and the vector is pre-rotated into that quadrant. The rotator has DW stages. The per-stage angle constants and the start amplitude, which includes the gain compensation, are computed from the parameters at elaboration.

Top module: `cordic_dds`

## Requirements
- R1: With `en` held high after reset, valid sample n (counting from 0) is the sine of phase (P0 + n·S) mod 2^PW. Here P0 is `phase_init` as captured during reset and S is `phase_step`, taken as an unsigned PW-bit number.
- R2: When OW equals DW, with PW=DW=16, each valid sample lies within 48 LSB of 32767·sin(2π·phase/65536).
- R3: `sample_valid_o` goes high after exactly DW+2 enabled clock edges following reset release, and stays high until the next reset.
- R4: A clock edge with `en` low leaves `sample_o` and `sample_valid_o` unchanged. Later samples continue the phase sequence without skipping a step.
- R5: When OW < DW, the output equals min((v + 2^(DW-OW-1)) >>> (DW-OW), 2^(OW-1)−1). Here v is the signed DW-bit rotator result, which is the output of an otherwise identical instance with OW = DW.
- R6: When OW > DW, the output equals v shifted left by OW−DW, so its low OW−DW bits are zero.
- R7: While `rst_n` is low, `sample_valid_o` is low and `phase_init` is loaded as the starting phase. Changes to `phase_init` while `rst_n` is high have no effect.
- R8: The rotator result v is clamped to ±(2^(DW-1)−1). It never takes the most negative code, so for OW ≥ DW the output magnitude never exceeds (2^(DW-1)−1)·2^(OW-DW).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the valid chain; loads the start phase |
| en | input | 1 | Downstream enable; the whole datapath advances only when high |
| phase_init | input | PW | Start phase, captured while reset is asserted |
| phase_step | input | PW | Tuning word added to the phase on each enabled cycle |
| sample_o | output | OW | Signed sine sample |
| sample_valid_o | output | 1 | High once the pipeline holds a sample of the current sequence |

## Verification
Every result is counted in enabled edges, not in clock cycles. The first valid sample, for phase P0, appears after DW+2 enabled edges. Each further enabled edge brings the next phase of the sequence, and an edge with `en` low brings nothing new. The bench drives inputs and samples outputs on the falling edge. It tracks enabled edges itself to decide which sample index is due, and compares the outputs of three instances with OW equal to, narrower than and wider than DW, all fed the same stimulus.

// File: rtl/cordic_dds.sv
module cordic_dds #(
  parameter int PW = 16,
  parameter int DW = 16,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] phase_init,
  input  logic [PW-1:0] phase_step,
  output logic [OW-1:0] sample_o,
  output logic          sample_valid_o
);
  localparam int  IW  = DW + 1;
  localparam int  ZW  = PW + 1;
  localparam int  LAT = DW + 2;
  localparam real PI  = 3.14159265358979323846;

  function automatic real comp_gain();
    real k = 1.0;
    for (int i = 0; i < DW; i++) k = k / $sqrt(1.0 + 2.0 ** (-2.0 * i));
    return k;
  endfunction

  function automatic logic signed [ZW-1:0] atan_units(input int i);
    real a = $atan(2.0 ** (-1.0 * i)) * (2.0 ** PW) / (2.0 * PI);
    return ZW'($rtoi(a + 0.5));
  endfunction

  localparam logic signed [IW-1:0] X0   = IW'($rtoi(comp_gain() * (2.0 ** (DW - 1) - 1.0) + 0.5));
  localparam logic signed [IW-1:0] YMAX = IW'((64'sd1 <<< (DW - 1)) - 1);
  localparam logic signed [IW-1:0] YMIN = -YMAX;

  logic [PW-1:0]          acc;
  logic [LAT-1:0]         vsr;
  logic signed [IW-1:0]   xa [0:DW];
  logic signed [IW-1:0]   ya [0:DW];
  logic signed [ZW-1:0]   za [0:DW];
  logic signed [DW-1:0]   yc;
  logic [OW-1:0]          adapted;

  always_ff @(posedge clk)
    if (!rst_n)  acc <= phase_init;
    else if (en) acc <= acc + phase_step;

  always_ff @(posedge clk)
    if (!rst_n)  vsr <= '0;
    else if (en) vsr <= {vsr[LAT-2:0], 1'b1};

  assign sample_valid_o = vsr[LAT-1];

  always_ff @(posedge clk)
    if (en) begin
      unique case (acc[PW-1 -: 2])
        2'd0: begin xa[0] <= X0;       ya[0] <= '0;  end
        2'd1: begin xa[0] <= '0;       ya[0] <= X0;  end
        2'd2: begin xa[0] <= -X0;      ya[0] <= '0;  end
        default: begin xa[0] <= '0;    ya[0] <= -X0; end
      endcase
      za[0] <= {3'b000, acc[PW-3:0]};
    end

  for (genvar i = 1; i <= DW; i++) begin : g_stage
    localparam logic signed [ZW-1:0] ANG = atan_units(i - 1);
    logic signed [IW-1:0] xs, ys;
    assign xs = xa[i-1] >>> (i - 1);
    assign ys = ya[i-1] >>> (i - 1);
    always_ff @(posedge clk)
      if (en) begin
        if (za[i-1] >= 0) begin
          xa[i] <= xa[i-1] - ys;
          ya[i] <= ya[i-1] + xs;
          za[i] <= za[i-1] - ANG;
        end else begin
          xa[i] <= xa[i-1] + ys;
          ya[i] <= ya[i-1] - xs;
          za[i] <= za[i-1] + ANG;
        end
      end
  end

  assign yc = (ya[DW] > YMAX) ? YMAX[DW-1:0] :
              (ya[DW] < YMIN) ? YMIN[DW-1:0] : ya[DW][DW-1:0];

  if (OW < DW) begin : g_narrow
    localparam int D = DW - OW;
    localparam logic signed [OW:0] OMAX = (OW + 1)'((64'sd1 <<< (OW - 1)) - 1);
    logic signed [DW:0] t;
    logic signed [OW:0] r;
    assign t = {yc[DW-1], yc} + (DW + 1)'(64'sd1 <<< (D - 1));
    assign r = t[DW:D];
    assign adapted = (r > OMAX) ? OMAX[OW-1:0] : r[OW-1:0];
  end else if (OW > DW) begin : g_widen
    assign adapted = {yc, {(OW - DW){1'b0}}};
  end else begin : g_same
    assign adapted = yc;
  end

  always_ff @(posedge clk)
    if (en) sample_o <= adapted;

endmodule

// File: rtl/cordic_dds_chk.sv
module cordic_dds_chk #(
  parameter int PW = 16,
  parameter int DW = 16,
  parameter int OW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [OW-1:0] sample_o,
  input logic          sample_valid_o
);
  localparam int CW = $clog2(DW + 3) + 1;
  localparam logic [CW-1:0] LC = CW'(DW + 2);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk)
    if (!rst_n)                cnt <= '0;
    else if (en && cnt < LC)   cnt <= cnt + 1'b1;

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid_o == (cnt == LC));

  p_valid_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid_o |=> sample_valid_o);

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && sample_valid_o) |=> ($stable(sample_o) && $stable(sample_valid_o)));

  if (OW > DW) begin : g_wide
    p_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid_o |-> (sample_o[OW-DW-1:0] == '0));
  end

  if (OW >= DW) begin : g_bound
    localparam logic signed [OW:0] BND = (OW + 1)'(((64'sd1 <<< (DW - 1)) - 1) <<< (OW - DW));
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid_o |-> ($signed({sample_o[OW-1], sample_o}) <= BND &&
                          $signed({sample_o[OW-1], sample_o}) >= -BND));
  end
endmodule

bind cordic_dds cordic_dds_chk #(.PW(PW), .DW(DW), .OW(OW)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en),
  .sample_o(sample_o), .sample_valid_o(sample_valid_o));

// File: tb/cordic_dds_tb.sv
module cordic_dds_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 16;
  localparam int DW = 16;
  localparam int LAT = DW + 2;
  localparam real PI = 3.14159265358979323846;
  localparam real TOL = 48.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [PW-1:0] phase_init = '0;
  logic [PW-1:0] phase_step = '0;
  logic signed [15:0] s16;
  logic signed [11:0] s12;
  logic signed [19:0] s20;
  logic v16, v12, v20;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cordic_dds #(.PW(PW), .DW(DW), .OW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .phase_init(phase_init), .phase_step(phase_step),
    .sample_o(s16), .sample_valid_o(v16));
  cordic_dds #(.PW(PW), .DW(DW), .OW(12)) dut_nar_i (
    .clk(clk), .rst_n(rst_n), .en(en), .phase_init(phase_init), .phase_step(phase_step),
    .sample_o(s12), .sample_valid_o(v12));
  cordic_dds #(.PW(PW), .DW(DW), .OW(20)) dut_wid_i (
    .clk(clk), .rst_n(rst_n), .en(en), .phase_init(phase_init), .phase_step(phase_step),
    .sample_o(s20), .sample_valid_o(v20));

  task automatic check(input bit ok, input string what, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic check_sample(input string tc, input int n, input logic [PW-1:0] ph);
    real e, d;
    int v, en12;
    e = 32767.0 * $sin(2.0 * PI * real'(ph) / 65536.0);
    v = int'(s16);
    d = real'(v) - e;
    check(d <= TOL && d >= -TOL, $sformatf("%s R1/R2 sample %0d phase %0d", tc, n, ph), v, $rtoi(e));
    en12 = (v + 8) >>> 4;
    if (en12 > 2047) en12 = 2047;
    check(int'(s12) == en12, $sformatf("%s R5 sample %0d", tc, n), s12, en12);
    check(int'(s20) == v * 16, $sformatf("%s R6 sample %0d", tc, n), s20, v * 16);
    check(v != -32768, $sformatf("%s R8 sample %0d", tc, n), v, -32767);
  endtask

  task automatic run_case(input string tc, input logic [PW-1:0] init, input logic [PW-1:0] step,
                          input int nsamp, input int stall_mod);
    int n, edges, cyc;
    logic signed [15:0] p16;
    logic signed [11:0] p12;
    logic signed [19:0] p20;
    logic pv;
    bit en_now;
    rst_n = 1'b0; en = 1'b1; phase_init = init; phase_step = step;
    repeat (3) @(negedge clk);
    check(!v16 && !v12 && !v20, {tc, " R7 valid low in reset"}, v16, 0);
    rst_n = 1'b1;
    phase_init = ~init ^ 16'h5a5a;
    n = -1; edges = 0; cyc = 0;
    p16 = s16; p12 = s12; p20 = s20; pv = v16;
    while (n + 1 < nsamp && cyc < 4000) begin
      en_now = (stall_mod == 0) ? 1'b1 : ((cyc % stall_mod) != 0);
      en = en_now;
      @(negedge clk);
      cyc++;
      if (en_now) begin
        edges++;
        check(v16 == (edges >= LAT), $sformatf("%s R3 valid after %0d enabled edges", tc, edges),
              v16, edges >= LAT);
        if (v16) begin
          n++;
          check_sample(tc, n, init + PW'(n) * step);
        end
      end else begin
        check(s16 == p16 && s12 == p12 && s20 == p20 && v16 == pv,
              $sformatf("%s R4 hold on stall cycle %0d", tc, cyc), s16, p16);
      end
      p16 = s16; p12 = s12; p20 = s20; pv = v16;
    end
    check(n + 1 == nsamp, {tc, " sample count"}, n + 1, nsamp);
    en = 1'b0;
  endtask

  task automatic t_latency();   run_case("latency",   16'h0000, 16'd1024, 64, 0);  endtask
  task automatic t_sweep();     run_case("sweep",     16'h1234, 16'd257, 260, 0);  endtask
  task automatic t_peak();      run_case("peak",      16'h4000, 16'h0000, 8, 0);   endtask
  task automatic t_quadrants(); run_case("quadrants", 16'h2000, 16'h4000, 16, 0);  endtask
  task automatic t_stall();     run_case("stall",     16'd777,  16'd1234, 100, 3); endtask
  task automatic t_reverse();   run_case("reverse",   16'd5,    16'hfff3, 100, 5); endtask

  initial begin
    t_latency();
    t_sweep();
    t_peak();
    t_quadrants();
    t_stall();
    t_reverse();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule